// File: doc/BRIEF.md
# DMA Control and Status Register Unit

This unit is the software-facing register front end of a single-channel DMA engine. A four-word register window exposes a 32-bit control/status word, a transfer address and a down-counting byte count. The fourth word is a diagnostic slot. Every control/status bit has its own access rule:

- Some bits are plain read/write.
- Some mirror live state from the data mover.
- One is a write-1 pulse that never reads back.
- Some are sticky event flags.
- One field is a fixed device identifier.

The data mover pulses a byte strobe for each byte it moves. The unit counts the programmed byte count down to zero and raises terminal count once when the last byte is reported. It also combines the pending flags with their enables into a single registered interrupt line. A software-held engine reset bit keeps the engine and every sticky flag cleared until software drops it again.

Top module: `dma_regs_top`

## Requirements
- R1: Word index 0 on `bus_addr` is the control/status word, 1 the address, 2 the byte count and 3 the diagnostic word. The diagnostic word always reads 0 and ignores writes. Read data appears on `bus_rdata` one clock after a read request (`bus_sel`=1, `bus_we`=0).
- R2: Control/status bits 31:28 always read 0x9, and writes to them are ignored. Bits 19:16 and every bit not named in R3 to R10 always read 0.
- R3: Bit 7 (engine reset) is read/write and is not self-clearing, and `eng_reset` follows it. While it is 1, the byte count, terminal count (bit 14), error pending (bit 1) and pack count (bits 3:2) are forced to 0, and writes to the byte count are ignored.
- R4: Writing 1 to bit 5 (flush) clears pack count, error pending and terminal count. Bit 5 always reads 0.
- R5: The byte count decrements by one for each cycle with `byte_strobe`=1 while bit 9 is 1 and bit 7 is 0. It stops at zero. Terminal count (bit 14) becomes 1 on the step from 1 to 0 and stays 1.
- R6: Bit 0 (interrupt pending) is registered from `periph_irq` OR (terminal count AND NOT bit 23). Bit 23 is the terminal-count interrupt disable and is read/write.
- R7: `irq` is registered as bit 4 (interrupt enable) AND (bit 0 OR bit 1).
- R8: Bits 3:2 hold the `pack_in` value captured on each `pack_upd` pulse. Bits 12:11 show `byte_off_in` live. Writes to both fields are ignored.
- R9: Bits 9 (enable) and 8 (direction, 1 = device to memory) are read/write and drive `eng_enable` and `eng_to_mem`.
- R10: Error pending (bit 1) is set by an `err_strobe` pulse and stays set until a flush or the engine reset bit clears it.
- R11: The address word is 32-bit read/write and drives `dma_addr`.
- R12: Writing the byte-count word loads its low CNT_W bits (24 by default). Reads return the count zero-extended.
- R13: A synchronous `rst` clears every stored bit. After it, the control/status word reads 0x9000_0000 when `periph_irq` and `byte_off_in` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| byte_strobe | input | 1 | One byte moved by the data mover |
| pack_upd | input | 1 | Capture a new pack count |
| pack_in | input | 2 | Bytes currently in the pack register |
| byte_off_in | input | 2 | Current byte offset |
| err_strobe | input | 1 | Slave error event |
| periph_irq | input | 1 | Attached peripheral interrupt level |
| dma_addr | output | 32 | Programmed transfer address |
| eng_enable | output | 1 | Engine enable |
| eng_to_mem | output | 1 | Direction: device to memory |
| eng_reset | output | 1 | Engine held in reset |
| irq | output | 1 | Registered interrupt output |

## Verification
The assertions assume the following about the inputs:

- A flush write does not coincide with an error strobe, a pack update or a byte strobe. When those events do coincide, the event wins, and the flush property does not cover that case.
- Any byte-count write happens while no decrement is due. The counter-stops property only excludes writes to word 2.
- The first cycles after `rst` carry no event strobes.

The stimulus keeps to these conditions: every strobe and every register access is a separate one-cycle pulse on a falling edge. The sweeps walk byte counts from 1 to 5 and every combination of interrupt enable, terminal-count disable and peripheral interrupt.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  localparam int W_CSR  = 0;
  localparam int W_ADDR = 1;
  localparam int W_CNT  = 2;
  localparam int W_DIAG = 3;

  localparam int B_IP     = 0;
  localparam int B_EP     = 1;
  localparam int B_PACK   = 2;
  localparam int B_IE     = 4;
  localparam int B_FLUSH  = 5;
  localparam int B_RST    = 7;
  localparam int B_DIR    = 8;
  localparam int B_EN     = 9;
  localparam int B_OFF    = 11;
  localparam int B_TC     = 14;
  localparam int B_DTCI   = 23;
  localparam int B_ID     = 28;
  localparam logic [3:0] DEV_ID = 4'h9;

  typedef struct packed {
    logic dtci;
    logic en;
    logic dir;
    logic rstb;
    logic ie;
  } csr_ctl_t;
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode #(
  parameter int NW  = 4,
  parameter int AW  = 2,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] rd_words [NW],
  output logic [NW-1:0] wr_hit,
  output logic [DW-1:0] rdata
);
  genvar gi;
  generate
    for (gi = 0; gi < NW; gi++) begin : g_hit
      assign wr_hit[gi] = sel & we & (addr == AW'(gi));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (sel && !we) begin
      rdata <= rd_words[addr];
    end
  end
endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             strobe,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             tc_evt
);
  logic nonzero;
  logic dec;

  assign nonzero = |cnt;
  assign dec     = strobe & run & nonzero & ~load & ~clr;
  assign tc_evt  = dec & (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec) begin
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dma_csr_bits.sv
module dma_csr_bits
  import dma_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  csr_ctl_t   wr_ctl,
  input  logic       wr_flush,
  input  logic       tc_evt,
  input  logic       err_strobe,
  input  logic       pack_upd,
  input  logic [1:0] pack_in,
  output csr_ctl_t   ctl,
  output logic       tc,
  output logic       ep,
  output logic [1:0] pack
);
  logic flush;
  assign flush = we & wr_flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (we) begin
      ctl <= wr_ctl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.rstb) begin
      tc <= 1'b0;
    end else if (tc_evt) begin
      tc <= 1'b1;
    end else if (flush) begin
      tc <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.rstb) begin
      ep <= 1'b0;
    end else if (err_strobe) begin
      ep <= 1'b1;
    end else if (flush) begin
      ep <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.rstb) begin
      pack <= '0;
    end else if (pack_upd) begin
      pack <= pack_in;
    end else if (flush) begin
      pack <= '0;
    end
  end
endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic tc,
  input  logic dtci,
  input  logic periph,
  input  logic ie,
  input  logic ep,
  output logic ip,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ip  <= 1'b0;
      irq <= 1'b0;
    end else begin
      ip  <= periph | (tc & ~dtci);
      irq <= ie & (ip | ep);
    end
  end
endmodule

// File: rtl/dma_regs_top.sv
module dma_regs_top
  import dma_regs_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_sel,
  input  logic                       bus_we,
  input  logic [dma_regs_pkg::IDX_W-1:0]  bus_addr,
  input  logic [dma_regs_pkg::WORD_W-1:0] bus_wdata,
  output logic [dma_regs_pkg::WORD_W-1:0] bus_rdata,
  input  logic                       byte_strobe,
  input  logic                       pack_upd,
  input  logic [1:0]                 pack_in,
  input  logic [1:0]                 byte_off_in,
  input  logic                       err_strobe,
  input  logic                       periph_irq,
  output logic [dma_regs_pkg::WORD_W-1:0] dma_addr,
  output logic                       eng_enable,
  output logic                       eng_to_mem,
  output logic                       eng_reset,
  output logic                       irq
);
  logic [NUM_WORDS-1:0] wr_hit;
  logic [WORD_W-1:0]    rd_words [NUM_WORDS];
  logic [WORD_W-1:0]    csr_word;
  logic [WORD_W-1:0]    addr_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 tc_evt;
  logic                 tc_q;
  logic                 ep_q;
  logic                 ip_q;
  logic [1:0]           pack_q;
  csr_ctl_t             ctl_q;
  csr_ctl_t             wr_ctl;
  logic                 ie_bit;
  logic                 rst_bit;

  assign wr_ctl.dtci = bus_wdata[B_DTCI];
  assign wr_ctl.en   = bus_wdata[B_EN];
  assign wr_ctl.dir  = bus_wdata[B_DIR];
  assign wr_ctl.rstb = bus_wdata[B_RST];
  assign wr_ctl.ie   = bus_wdata[B_IE];

  dma_reg_decode #(.NW(NUM_WORDS), .AW(IDX_W), .DW(WORD_W)) dec_i (
    .clk      (clk),
    .rst      (rst),
    .sel      (bus_sel),
    .we       (bus_we),
    .addr     (bus_addr),
    .rd_words (rd_words),
    .wr_hit   (wr_hit),
    .rdata    (bus_rdata)
  );

  dma_csr_bits csr_i (
    .clk        (clk),
    .rst        (rst),
    .we         (wr_hit[W_CSR]),
    .wr_ctl     (wr_ctl),
    .wr_flush   (bus_wdata[B_FLUSH]),
    .tc_evt     (tc_evt),
    .err_strobe (err_strobe),
    .pack_upd   (pack_upd),
    .pack_in    (pack_in),
    .ctl        (ctl_q),
    .tc         (tc_q),
    .ep         (ep_q),
    .pack       (pack_q)
  );

  dma_byte_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (ctl_q.rstb),
    .load     (wr_hit[W_CNT]),
    .load_val (bus_wdata[CNT_W-1:0]),
    .strobe   (byte_strobe),
    .run      (ctl_q.en),
    .cnt      (cnt_q),
    .tc_evt   (tc_evt)
  );

  dma_irq_gen irq_i (
    .clk    (clk),
    .rst    (rst),
    .tc     (tc_q),
    .dtci   (ctl_q.dtci),
    .periph (periph_irq),
    .ie     (ctl_q.ie),
    .ep     (ep_q),
    .ip     (ip_q),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (wr_hit[W_ADDR]) begin
      addr_q <= bus_wdata;
    end
  end

  always_comb begin
    csr_word             = '0;
    csr_word[B_ID+:4]    = DEV_ID;
    csr_word[B_DTCI]     = ctl_q.dtci;
    csr_word[B_TC]       = tc_q;
    csr_word[B_OFF+:2]   = byte_off_in;
    csr_word[B_EN]       = ctl_q.en;
    csr_word[B_DIR]      = ctl_q.dir;
    csr_word[B_RST]      = ctl_q.rstb;
    csr_word[B_IE]       = ctl_q.ie;
    csr_word[B_PACK+:2]  = pack_q;
    csr_word[B_EP]       = ep_q;
    csr_word[B_IP]       = ip_q;
  end

  assign rd_words[W_CSR]  = csr_word;
  assign rd_words[W_ADDR] = addr_q;
  assign rd_words[W_CNT]  = WORD_W'(cnt_q);
  assign rd_words[W_DIAG] = '0;

  assign ie_bit     = ctl_q.ie;
  assign rst_bit    = ctl_q.rstb;
  assign dma_addr   = addr_q;
  assign eng_enable = ctl_q.en;
  assign eng_to_mem = ctl_q.dir;
  assign eng_reset  = ctl_q.rstb;
endmodule

// File: rtl/dma_regs_chk.sv
module dma_regs_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             byte_strobe,
  input logic             err_strobe,
  input logic             pack_upd,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             tc,
  input logic             ep,
  input logic [1:0]       pack,
  input logic             ie,
  input logic             rst_bit
);
  logic csr_rd;
  logic csr_wr;
  logic cnt_wr;
  assign csr_rd = bus_sel & ~bus_we & (bus_addr == 2'd0);
  assign csr_wr = bus_sel &  bus_we & (bus_addr == 2'd0);
  assign cnt_wr = bus_sel &  bus_we & (bus_addr == 2'd2);

  p_fixed_fields_r2: assert property (@(posedge clk) disable iff (rst)
    csr_rd |=> (bus_rdata[31:28] == 4'h9 && bus_rdata[19:16] == 4'h0 && !bus_rdata[5]));

  p_rst_clears_r3: assert property (@(posedge clk) disable iff (rst)
    rst_bit |=> (cnt == '0 && !tc && !ep && pack == 2'd0));

  p_rst_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (rst_bit && !csr_wr) |=> rst_bit);

  p_flush_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && bus_wdata[5] && !err_strobe && !pack_upd && !byte_strobe)
      |=> (!tc && !ep && pack == 2'd0));

  p_cnt_stops_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !cnt_wr) |=> cnt == '0);

  p_tc_on_last_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(tc) |-> $past(cnt) == CNT_W'(1));

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie));
endmodule

bind dma_regs_top dma_regs_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .byte_strobe (byte_strobe),
  .err_strobe  (err_strobe),
  .pack_upd    (pack_upd),
  .irq         (irq),
  .cnt         (cnt_q),
  .tc          (tc_q),
  .ep          (ep_q),
  .pack        (pack_q),
  .ie          (ie_bit),
  .rst_bit     (rst_bit)
);

// File: tb/dma_regs_tb.sv
module dma_regs_top_tb_top;
  localparam logic [31:0] C_IP    = 32'h1;
  localparam logic [31:0] C_EP    = 32'h2;
  localparam logic [31:0] C_IE    = 32'h10;
  localparam logic [31:0] C_FLUSH = 32'h20;
  localparam logic [31:0] C_RST   = 32'h80;
  localparam logic [31:0] C_DIR   = 32'h100;
  localparam logic [31:0] C_EN    = 32'h200;
  localparam logic [31:0] C_TC    = 32'h4000;
  localparam logic [31:0] C_DTCI  = 32'h80_0000;
  localparam logic [31:0] C_ID    = 32'h9000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        byte_strobe = 1'b0;
  logic        pack_upd = 1'b0;
  logic [1:0]  pack_in = 2'd0;
  logic [1:0]  byte_off_in = 2'd0;
  logic        err_strobe = 1'b0;
  logic        periph_irq = 1'b0;
  logic [31:0] dma_addr;
  logic        eng_enable, eng_to_mem, eng_reset, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dma_regs_top dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .byte_strobe(byte_strobe), .pack_upd(pack_upd), .pack_in(pack_in),
    .byte_off_in(byte_off_in), .err_strobe(err_strobe),
    .periph_irq(periph_irq), .dma_addr(dma_addr),
    .eng_enable(eng_enable), .eng_to_mem(eng_to_mem),
    .eng_reset(eng_reset), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); byte_strobe = 1'b1;
    @(negedge clk); byte_strobe = 1'b0;
  endtask

  task automatic err_pulse();
    @(negedge clk); err_strobe = 1'b1;
    @(negedge clk); err_strobe = 1'b0;
  endtask

  task automatic pack_pulse(input logic [1:0] v);
    @(negedge clk); pack_upd = 1'b1; pack_in = v;
    @(negedge clk); pack_upd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    idle(3);
    @(negedge clk); rst = 1'b0;

    // R13: reset state
    rd(2'd0, d); chk("R13 csr after reset", d, C_ID);
    chk("R13 outputs after reset", {28'd0, irq, eng_enable, eng_to_mem, eng_reset}, 32'd0);
    chk("R13 dma_addr after reset", dma_addr, 32'd0);

    // R2: fixed and reserved bits, flush reads 0
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    chk("R2 csr all-ones write", d, C_ID | C_DTCI | C_EN | C_DIR | C_RST | C_IE);
    wr(2'd0, 32'd0);

    // R1: diagnostic word, R11 address, R12 count
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, d); chk("R1 diag reads zero", d, 32'd0);
    wr(2'd1, 32'hDEAD_BEEF); rd(2'd1, d); chk("R11 address readback", d, 32'hDEAD_BEEF);
    chk("R11 dma_addr port", dma_addr, 32'hDEAD_BEEF);
    wr(2'd2, 32'hFFAB_CDEF); rd(2'd2, d); chk("R12 count readback", d, 32'h00AB_CDEF);

    // R9: enable and direction
    wr(2'd0, C_EN | C_DIR);
    chk("R9 enable and dir outputs", {30'd0, eng_enable, eng_to_mem}, 32'd3);
    wr(2'd0, 32'd0);
    chk("R9 enable and dir cleared", {30'd0, eng_enable, eng_to_mem}, 32'd0);

    // R5: no count while disabled
    wr(2'd2, 32'd4); strobe(); strobe();
    rd(2'd2, d); chk("R5 disabled counter holds", d, 32'd4);

    // R5: count sweep with terminal count
    for (int n = 1; n <= 5; n++) begin
      wr(2'd0, C_EN | C_FLUSH);
      wr(2'd2, n);
      for (int k = 1; k <= n + 1; k++) begin
        strobe();
        rd(2'd2, d); chk("R5 count value", d, (k >= n) ? 32'd0 : 32'(n - k));
        rd(2'd0, d); chk("R5 terminal count", d & C_TC, (k >= n) ? C_TC : 32'd0);
      end
    end

    // R6/R7: interrupt sweep with terminal count held at 1
    wr(2'd0, C_EN | C_FLUSH);
    wr(2'd2, 32'd1); strobe();
    for (int m = 0; m < 8; m++) begin
      logic ie_v, dtci_v, per_v;
      ie_v = m[0]; dtci_v = m[1]; per_v = m[2];
      periph_irq = per_v;
      wr(2'd0, C_EN | (ie_v ? C_IE : 32'd0) | (dtci_v ? C_DTCI : 32'd0));
      idle(3);
      chk("R7 irq combination", {31'd0, irq}, {31'd0, ie_v & (per_v | ~dtci_v)});
      rd(2'd0, d); chk("R6 pending bit", d & C_IP, (per_v | ~dtci_v) ? C_IP : 32'd0);
    end
    periph_irq = 1'b0;

    // R10/R4: error pending
    wr(2'd0, C_EN | C_IE | C_DTCI | C_FLUSH); idle(3);
    chk("R4 flush clears irq sources", {31'd0, irq}, 32'd0);
    err_pulse(); idle(3);
    chk("R10 error raises irq", {31'd0, irq}, 32'd1);
    idle(4);
    rd(2'd0, d); chk("R10 error pending sticky", d & C_EP, C_EP);
    wr(2'd0, C_EN | C_IE | C_DTCI | C_FLUSH); idle(3);
    rd(2'd0, d); chk("R4 flush clears error pending", d & (C_EP | C_TC), 32'd0);
    chk("R4 irq after flush", {31'd0, irq}, 32'd0);

    // R8: pack count and byte offset
    pack_pulse(2'd3);
    rd(2'd0, d); chk("R8 pack count", (d >> 2) & 32'd3, 32'd3);
    byte_off_in = 2'd2;
    rd(2'd0, d); chk("R8 byte offset", (d >> 11) & 32'd3, 32'd2);
    wr(2'd0, C_EN | 32'h0000_180C);
    rd(2'd0, d); chk("R8 fields ignore writes", d & 32'h0000_180C, 32'h0000_100C);
    byte_off_in = 2'd0;
    wr(2'd0, C_EN | C_FLUSH);
    rd(2'd0, d); chk("R4 flush clears pack", d & 32'hC, 32'd0);

    // R3: engine reset bit
    wr(2'd2, 32'd5); strobe(); err_pulse(); pack_pulse(2'd2);
    wr(2'd0, C_EN | C_RST); idle(2);
    chk("R3 eng_reset output", {31'd0, eng_reset}, 32'd1);
    rd(2'd0, d); chk("R3 flags cleared", d & (C_RST | C_TC | C_EP | 32'hC), C_RST);
    rd(2'd2, d); chk("R3 count cleared", d, 32'd0);
    idle(5);
    rd(2'd0, d); chk("R3 reset bit not self-clearing", d & C_RST, C_RST);
    wr(2'd2, 32'd7); rd(2'd2, d); chk("R3 count write ignored", d, 32'd0);
    wr(2'd0, C_EN);
    chk("R3 eng_reset released", {31'd0, eng_reset}, 32'd0);
    wr(2'd2, 32'd3); rd(2'd2, d); chk("R12 count after release", d, 32'd3);

    finish_run();
  end
endmodule